// File: doc/BRIEF.md
# Dummy-Byte Snooping Injector for a Serial Flash Write Path

This block sits between software byte writes and a serial flash shifter while the controller is in its software-driven (user) mode. When chip select goes active it starts to watch the writes. The low byte of the first write is read as a flash opcode and looked up in a table that gives the number of dummy units that opcode needs. One unit is eight bytes. The block keeps a running byte index, which each write advances by its size.

When the index reaches the address width plus one, the block acts. The address width is three bytes, or four when the wide-address input is set. The write presented at that point is swallowed and not forwarded. The block then emits the pending dummy bytes on its own, each carrying the configured fill value, one byte per handshake with the shifter. Bus writes are held off until the last of those bytes has gone.

Outside snooping, writes pass straight through in the same cycle. This covers chip select low, the state after an opcode that needs no dummies, an unknown opcode, and the state after an injection.

Top module: `spi_dummy_snoop`

## Requirements
- R1: After reset no dummy byte is offered (dmyValid=0), wrReady is 1 and snooping is off, so writes pass through.
- R2: While csActive is 0, a write is forwarded in the same cycle: fwdValid=wrValid, fwdData=wrData, fwdSize=wrSize, suppress=0.
- R3: The clock edge that first sees csActive high arms snooping. The next accepted write's bits [7:0] are the opcode. Opcodes 0x02, 0x03, 0x12, 0x13, 0x32, 0x34, 0xA2 and any opcode not listed in R4 to R6 need zero units: snooping turns off, and that write and all later writes pass through.
- R4: Opcodes 0x0B, 0x3B, 0x3C, 0x6B and 0x6C need 1 unit (8 dummy bytes).
- R5: Opcodes 0x0C, 0xBB and 0xBC need 2 units (16 dummy bytes).
- R6: Opcodes 0xEB and 0xEC need 4 units (32 dummy bytes).
- R7: Every accepted write while snooping, the opcode write included, advances the index by wrSize (1 to 4 bytes). The dummy point is reached when the index is at least 4 with addr4Byte=0, or at least 5 with addr4Byte=1. Writes before that point pass through.
- R8: The write accepted at the dummy point is swallowed: suppress=1 and fwdValid=0 in that cycle. Snooping then turns off and later writes pass through.
- R9: After a swallowed write, dmyValid rises in the next cycle. Exactly units×8 bytes are offered, each with dmyData=fillByte. One byte is consumed on each cycle with dmyValid and dmyReady both high, and an offered byte stays offered while dmyReady is low.
- R10: While dummy bytes are pending, wrReady is 0 and a presented write is not forwarded.
- R11: Dropping csActive ends snooping and discards any pending dummy bytes. dmyValid is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csActive | input | 1 | Chip select asserted (level) |
| addr4Byte | input | 1 | Four-byte address mode |
| fillByte | input | 8 | Value placed in every injected dummy byte |
| wrValid | input | 1 | Software write presented |
| wrReady | output | 1 | Write accepted this cycle (low while injecting) |
| wrData | input | 32 | Write data, first byte in bits [7:0] |
| wrSize | input | 3 | Write size in bytes, 1 to 4 |
| fwdValid | output | 1 | Write forwarded to the shifter |
| fwdData | output | 32 | Forwarded write data |
| fwdSize | output | 3 | Forwarded write size |
| suppress | output | 1 | Current write swallowed at the dummy point |
| dmyValid | output | 1 | An injected dummy byte is offered |
| dmyData | output | 8 | Injected dummy byte |
| dmyReady | input | 1 | Shifter takes the offered dummy byte |

## Verification
A wrong byte index shows up at the ports as a swallow on the wrong write. It appears either one write early, where an address byte vanishes, or one write late, where the first software dummy byte leaks into fwdValid. Either one is visible in the same cycle as that write. A wrong table entry or a wrong pending count appears as the wrong number of dmyValid cycles starting one cycle after the swallow. A stuck injection counter appears as wrReady held low or dummy bytes that survive a chip-select drop, visible on the very next cycle.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int UNIT_BYTES = 8;
  localparam int MAX_UNITS  = 4;
  localparam int CNT_W      = $clog2(MAX_UNITS * UNIT_BYTES + 1);
  localparam int UNITS_W    = $clog2(MAX_UNITS + 1);

  // control -> datapath strobes
  typedef struct packed {
    logic             swallow;
    logic             abort;
    logic [CNT_W-1:0] count;
  } strobe_t;

  function automatic logic [UNITS_W-1:0] dummyUnits(input logic [7:0] op);
    case (op)
      8'h0B, 8'h3B, 8'h3C, 8'h6B, 8'h6C: dummyUnits = UNITS_W'(1);
      8'h0C, 8'hBB, 8'hBC:               dummyUnits = UNITS_W'(2);
      8'hEB, 8'hEC:                      dummyUnits = UNITS_W'(4);
      default:                           dummyUnits = '0;
    endcase
  endfunction
endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int SIZE_W = 3,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              addr4Byte,
  input  logic              wrAccept,
  input  logic [7:0]        wrByte0,
  input  logic [SIZE_W-1:0] wrSize,
  output strobe_t           strb
);
  localparam logic [IDX_W-1:0] IDX_OFF   = '1;
  localparam logic [IDX_W-1:0] IDX_START = '0;

  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   pending;
  logic               csPrev;
  logic [IDX_W-1:0]   dummyPoint;
  logic               armed, atStart, atDummy, swallow;
  logic [UNITS_W-1:0] units;

  always_comb begin
    dummyPoint = addr4Byte ? IDX_W'(5) : IDX_W'(4);
    armed      = (idx != IDX_OFF);
    atStart    = (idx == IDX_START);
    atDummy    = armed && !atStart && (idx >= dummyPoint);
    swallow    = wrAccept && csActive && atDummy;
    units      = dummyUnits(wrByte0);
    strb.swallow = swallow;
    strb.abort   = !csActive;
    strb.count   = pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= IDX_OFF;
      pending <= '0;
      csPrev  <= 1'b0;
    end else begin
      csPrev <= csActive;
      if (!csActive) begin
        idx     <= IDX_OFF;
        pending <= '0;
      end else if (!csPrev) begin
        idx     <= IDX_START;
        pending <= '0;
      end else if (wrAccept && armed) begin
        if (atStart) begin
          if (units == '0) begin
            idx <= IDX_OFF;
          end else begin
            pending <= CNT_W'(int'(units) * UNIT_BYTES);
            idx     <= idx + IDX_W'(wrSize);
          end
        end else if (atDummy) begin
          idx     <= IDX_OFF;
          pending <= '0;
        end else begin
          idx <= idx + IDX_W'(wrSize);
        end
      end
    end
  end
endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        fillByte,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SIZE_W-1:0] wrSize,
  output logic              fwdValid,
  output logic [DATA_W-1:0] fwdData,
  output logic [SIZE_W-1:0] fwdSize,
  output logic              suppress,
  output logic              dmyValid,
  output logic [7:0]        dmyData,
  input  logic              dmyReady
);
  logic [CNT_W-1:0] injCnt;

  always_comb begin
    wrReady  = (injCnt == '0);
    fwdValid = wrValid && wrReady && !strb.swallow;
    fwdData  = wrData;
    fwdSize  = wrSize;
    suppress = strb.swallow;
    dmyValid = (injCnt != '0);
    dmyData  = fillByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      injCnt <= '0;
    end else if (strb.abort) begin
      injCnt <= '0;
    end else if (strb.swallow) begin
      injCnt <= strb.count;
    end else if (dmyValid && dmyReady) begin
      injCnt <= injCnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_dummy_snoop.sv
module spi_dummy_snoop
  import snoop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              addr4Byte,
  input  logic [7:0]        fillByte,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SIZE_W-1:0] wrSize,
  output logic              fwdValid,
  output logic [DATA_W-1:0] fwdData,
  output logic [SIZE_W-1:0] fwdSize,
  output logic              suppress,
  output logic              dmyValid,
  output logic [7:0]        dmyData,
  input  logic              dmyReady
);
  strobe_t strb;
  logic    wrAccept;

  assign wrAccept = wrValid && wrReady;

  snoop_ctrl #(.SIZE_W(SIZE_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .addr4Byte(addr4Byte),
    .wrAccept(wrAccept), .wrByte0(wrData[7:0]), .wrSize(wrSize), .strb(strb)
  );

  snoop_dp #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fillByte(fillByte),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData), .wrSize(wrSize),
    .fwdValid(fwdValid), .fwdData(fwdData), .fwdSize(fwdSize),
    .suppress(suppress), .dmyValid(dmyValid), .dmyData(dmyData),
    .dmyReady(dmyReady)
  );
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic wrValid,
  input logic wrReady,
  input logic fwdValid,
  input logic suppress,
  input logic dmyValid,
  input logic dmyReady
);
  // R10
  busy_backpressure_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmyValid |-> !wrReady);

  // R8
  swallow_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(suppress && fwdValid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmyValid && !dmyReady && csActive) |=> dmyValid);

  // R11
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !dmyValid);

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && wrValid && wrReady) |-> (fwdValid && !suppress));
endmodule

bind spi_dummy_snoop snoop_checker i_chk (
  .clk(clk), .rstN(rstN), .csActive(csActive), .wrValid(wrValid),
  .wrReady(wrReady), .fwdValid(fwdValid), .suppress(suppress),
  .dmyValid(dmyValid), .dmyReady(dmyReady)
);

// File: tb/test_spi_dummy_snoop.sv
module test_spi_dummy_snoop;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 0, rstN = 0, csActive = 0, addr4Byte = 0;
  logic [7:0]  fillByte = 8'h00;
  logic        wrValid = 0, wrReady;
  logic [31:0] wrData = '0;
  logic [2:0]  wrSize = 3'd1;
  logic        fwdValid, suppress, dmyValid, dmyReady = 1;
  logic [31:0] fwdData;
  logic [2:0]  fwdSize;
  logic [7:0]  dmyData;

  int checks = 0, errors = 0;
  bit done = 0;
  logic capFwd, capSup, capRdy;
  logic [31:0] capData;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dummy_snoop i_spi_dummy_snoop (
    .clk(clk), .rstN(rstN), .csActive(csActive), .addr4Byte(addr4Byte),
    .fillByte(fillByte), .wrValid(wrValid), .wrReady(wrReady),
    .wrData(wrData), .wrSize(wrSize), .fwdValid(fwdValid),
    .fwdData(fwdData), .fwdSize(fwdSize), .suppress(suppress),
    .dmyValid(dmyValid), .dmyData(dmyData), .dmyReady(dmyReady)
  );

  // {opcode, addr4Byte, expected dummy bytes}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'h03,1'b0,6'd0},  {8'h13,1'b1,6'd0},  {8'h02,1'b0,6'd0},
    {8'h12,1'b1,6'd0},  {8'hA2,1'b0,6'd0},  {8'h32,1'b0,6'd0},
    {8'h34,1'b1,6'd0},  {8'h55,1'b0,6'd0},  {8'h0B,1'b0,6'd8},
    {8'h3B,1'b1,6'd8},  {8'h3C,1'b0,6'd8},  {8'h6B,1'b0,6'd8},
    {8'h6C,1'b1,6'd8},  {8'hBB,1'b0,6'd16}, {8'h0C,1'b1,6'd16},
    {8'hBC,1'b0,6'd16}, {8'hEB,1'b0,6'd32}, {8'hEC,1'b1,6'd32}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [2:0] sz);
    @(negedge clk);
    wrValid = 1; wrData = d; wrSize = sz;
    #1;
    capFwd = fwdValid; capSup = suppress; capRdy = wrReady; capData = fwdData;
    @(posedge clk);
    #1 wrValid = 0;
  endtask

  task automatic armCs();
    @(negedge clk); csActive = 1;
    @(posedge clk);
  endtask

  task automatic dropCs();
    @(negedge clk); csActive = 0;
    @(posedge clk);
  endtask

  task automatic countDummies(input logic [7:0] fill, input string req, output int n);
    n = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk); #1;
      if (!dmyValid) break;
      if (dmyData !== fill) chk(0, req, dmyData, fill);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(dmyValid === 0, "R1 dmyValid after reset", dmyValid, 0);
    chk(wrReady === 1, "R1 wrReady after reset", wrReady, 1);
    @(negedge clk); rstN = 1;

    // R2 cs low pass-through
    doWrite(32'hDEADBEEF, 3'd4);
    chk(capFwd === 1 && capSup === 0, "R2 fwd with cs low", capFwd, 1);
    chk(capData === 32'hDEADBEEF, "R2 data unchanged", capData, 32'hDEADBEEF);
    doWrite(32'h000000EB, 3'd1);
    chk(capFwd === 1, "R1 opcode with cs low not snooped", capFwd, 1);

    // Table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op; logic a4; int expN; int aw;
      op = VEC[v][14:7]; a4 = VEC[v][6]; expN = int'(VEC[v][5:0]);
      aw = a4 ? 4 : 3;
      addr4Byte = a4; fillByte = op ^ 8'hA5;
      armCs();
      doWrite({24'h0, op}, 3'd1);
      chk(capFwd === 1, "R3 opcode write forwarded", capFwd, 1);
      for (int b = 0; b < aw; b++) begin
        doWrite(32'h10 + b, 3'd1);
        chk(capFwd === 1 && capSup === 0, "R7 address byte passes", capFwd, 1);
      end
      doWrite(32'h000000FF, 3'd1);
      if (expN == 0) begin
        chk(capFwd === 1 && capSup === 0, "R3 zero-dummy write passes", capFwd, 1);
      end else begin
        chk(capSup === 1 && capFwd === 0, "R8 dummy write swallowed", capSup, 1);
      end
      countDummies(op ^ 8'hA5, "R9 fill value", n);
      if (expN == 8)       chk(n == expN, "R4 one-unit count", n, expN);
      else if (expN == 16) chk(n == expN, "R5 two-unit count", n, expN);
      else if (expN == 32) chk(n == expN, "R6 four-unit count", n, expN);
      else                 chk(n == 0, "R3 no dummies", n, 0);
      doWrite(32'h000000AA, 3'd1);
      chk(capFwd === 1 && capSup === 0, "R8 off after dummy point", capFwd, 1);
      dropCs();
    end

    // R7 + R10: multi-byte write, back-pressure
    addr4Byte = 0; fillByte = 8'h3C; dmyReady = 0;
    armCs();
    doWrite(32'h000000EB, 3'd1);
    doWrite(32'h00332211, 3'd3);
    chk(capFwd === 1, "R7 size-3 address passes", capFwd, 1);
    doWrite(32'h000000FF, 3'd1);
    chk(capSup === 1, "R7 swallow at index 4", capSup, 1);
    @(negedge clk); wrValid = 1; wrData = 32'h77; wrSize = 3'd1; #1;
    chk(wrReady === 0, "R10 wrReady low while injecting", wrReady, 0);
    chk(fwdValid === 0, "R10 write not forwarded", fwdValid, 0);
    repeat (3) @(negedge clk);
    #1 chk(dmyValid === 1, "R9 byte held while stalled", dmyValid, 1);
    wrValid = 0; dmyReady = 1;
    countDummies(8'h3C, "R9 fill value", n);
    n = n + 1; // first byte consumed at the edge after dmyReady rose
    chk(n == 32, "R6 full count after stall", n, 32);
    dropCs();

    // R7 4-byte mode with size-4 write then R11 abort
    addr4Byte = 1; fillByte = 8'h5A; dmyReady = 0;
    armCs();
    doWrite(32'h3322110B, 3'd4);
    doWrite(32'h00000044, 3'd1);
    chk(capFwd === 1 && capSup === 0, "R7 fourth address byte passes", capFwd, 1);
    doWrite(32'h000000FF, 3'd1);
    chk(capSup === 1, "R7 swallow at index 5", capSup, 1);
    @(negedge clk); #1;
    chk(dmyValid === 1, "R9 injection starts", dmyValid, 1);
    csActive = 0;
    @(negedge clk); #1;
    chk(dmyValid === 0, "R11 injection aborted", dmyValid, 0);
    chk(wrReady === 1, "R11 wrReady restored", wrReady, 1);
    dmyReady = 1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule